// File: doc/BRIEF.md
# Barrel Rotate-Shift Unit with Flags

This block is the shift and rotate section of a small processor's ALU. It takes a 32-bit destination operand, a source operand whose low bits give the shift count, and the incoming carry and zero flags. A 6-bit operation code selects one of eight operations. The block returns a 32-bit result and new carry and zero flags. Any code outside the shift group leaves the operand and the flags as they were, so the unit can sit beside the other ALU sections on a shared operation bus.

All eight operations run on one logarithmic right-shifting network. The left-going operations and the bit reverse are made by mirroring the operand on the way in, on the way out, or both. Only one shifter is built and no separate left shifter is needed. Rotate-through-carry does not act as a 33-bit rotate. It fills every vacated position with the incoming carry. The result and both flags are registered, so an operation presented before a rising edge appears on the outputs just after that edge.

Top module: `rotshift_unit`

## Requirements
- R1: Operation codes 8 to 15 select, in this order: rotate right, rotate left, logical shift right, logical shift left, carry-fill rotate right, carry-fill rotate left, arithmetic shift right, bit reverse.
- R2: The count n is src_i[4:0] only. The upper 27 bits of src_i have no effect, so 0x7FFFFFFF counts 31, 0xFFFFFFFE counts 30 and 0x80000000 counts 0.
- R3: Rotate right gives res[i] = D[(i+n) mod 32] with carry D[0]. Rotate left gives res[i] = D[(i−n) mod 32] with carry D[31]. Both carry rules also hold for n = 0.
- R4: Logical shift right fills the top n bits with 0 and sets carry to D[0]. Logical shift left fills the low n bits with 0 and sets carry to D[31].
- R5: Carry-fill rotate right fills the top n bits with c_i, and carry-fill rotate left fills the low n bits with c_i. Their carries are D[0] and D[31] respectively.
- R6: Arithmetic shift right fills the top n bits with D[31] and sets carry to D[0].
- R7: Bit reverse gives res[i] = D[31−n−i] for i < 32−n, with 0 above that, and sets carry to D[0].
- R8: For codes 8 to 15, z_o is 1 exactly when the result is zero, whatever z_i is.
- R9: For every code 8 to 15 except the two carry-fill rotates, c_i and z_i change neither the result nor the flags.
- R10: For any code outside 8 to 15, res_o equals D, c_o equals c_i and z_o equals z_i.
- R11: Outputs change one rising clock edge after the inputs. A synchronous active-high reset clears res_o, c_o and z_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 6 | Operation code |
| dst_i | input | 32 | Destination operand D |
| src_i | input | 32 | Source operand; low 5 bits are the count |
| c_i | input | 1 | Incoming carry flag |
| z_i | input | 1 | Incoming zero flag |
| res_o | output | 32 | Registered result |
| c_o | output | 1 | Registered carry flag |
| z_o | output | 1 | Registered zero flag |

## Verification
The cases hardest to reach are those where the outcome depends only on bits the operation is supposed to discard. Examples are a source whose upper bits are set but whose low five bits are zero, and a carry-fill rotate whose count is zero, so the incoming carry must not leak in. The stimulus sweeps eight boundary values (0, 1, 2, both sign edges, both all-ones edges) as both operand and count, under all four flag combinations. It also adds directed sources that carry junk above bit 4, which forces the masked-count and zero-count paths on every operation.

// File: rtl/rsu_pkg.sv
package rsu_pkg;

  typedef enum logic [1:0] {
    FILL_WRAP  = 2'd0,
    FILL_ZERO  = 2'd1,
    FILL_CARRY = 2'd2,
    FILL_SIGN  = 2'd3
  } fill_e;

  typedef struct packed {
    logic  active;      // code lies in the shift group
    logic  mirror_in;   // bit-reverse operand before the shifter
    logic  mirror_out;  // bit-reverse shifter output
    fill_e fill;        // source of vacated bits
    logic  c_from_msb;  // carry taken from D msb (else lsb)
  } rsu_ctl_t;

  localparam int unsigned GROUP_SIZE = 8;

endpackage

// File: rtl/rsu_decode.sv
module rsu_decode
  import rsu_pkg::*;
#(
  parameter int OP_W    = 6,
  parameter int OP_BASE = 8
) (
  input  logic [OP_W-1:0] op,
  output rsu_ctl_t        ctl
);
  localparam int SEL_W = $clog2(GROUP_SIZE);

  logic [OP_W-1:0]  rel;
  logic [SEL_W-1:0] sel;

  always_comb begin
    rel = op - OP_W'(OP_BASE);
    sel = rel[SEL_W-1:0];
    ctl = '{active: 1'b0, mirror_in: 1'b0, mirror_out: 1'b0,
            fill: FILL_WRAP, c_from_msb: 1'b0};
    if ((int'(op) >= OP_BASE) && (int'(op) < OP_BASE + int'(GROUP_SIZE))) begin
      ctl.active = 1'b1;
      case (sel)
        3'd0: ctl.fill = FILL_WRAP;                       // rotate right
        3'd1: begin                                       // rotate left
          ctl.mirror_in = 1'b1; ctl.mirror_out = 1'b1;
          ctl.fill = FILL_WRAP; ctl.c_from_msb = 1'b1;
        end
        3'd2: ctl.fill = FILL_ZERO;                       // shift right
        3'd3: begin                                       // shift left
          ctl.mirror_in = 1'b1; ctl.mirror_out = 1'b1;
          ctl.fill = FILL_ZERO; ctl.c_from_msb = 1'b1;
        end
        3'd4: ctl.fill = FILL_CARRY;                      // carry-fill right
        3'd5: begin                                       // carry-fill left
          ctl.mirror_in = 1'b1; ctl.mirror_out = 1'b1;
          ctl.fill = FILL_CARRY; ctl.c_from_msb = 1'b1;
        end
        3'd6: ctl.fill = FILL_SIGN;                       // arithmetic right
        default: begin                                    // reverse
          ctl.mirror_in = 1'b1; ctl.fill = FILL_ZERO;
        end
      endcase
    end
  end
endmodule

// File: rtl/rsu_barrel.sv
module rsu_barrel #(
  parameter int W  = 32,
  parameter int CW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  input  logic          wrap,
  input  logic          fill_bit,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stg [0:CW];

  assign stg[0] = din;

  for (genvar k = 0; k < CW; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [W-1:0] moved;
    always_comb begin
      moved = stg[k] >> SH;
      for (int b = 0; b < SH; b++) begin
        moved[W-SH+b] = wrap ? stg[k][b] : fill_bit;
      end
    end
    assign stg[k+1] = amt[k] ? moved : stg[k];
  end

  assign dout = stg[CW];
endmodule

// File: rtl/rsu_flags.sv
module rsu_flags #(
  parameter int W = 32
) (
  input  logic         active,
  input  logic         c_from_msb,
  input  logic [W-1:0] dst,
  input  logic [W-1:0] res,
  input  logic         c_in,
  input  logic         z_in,
  output logic         c_out,
  output logic         z_out
);
  always_comb begin
    if (active) begin
      c_out = c_from_msb ? dst[W-1] : dst[0];
      z_out = ~|res;
    end else begin
      c_out = c_in;
      z_out = z_in;
    end
  end
endmodule

// File: rtl/rotshift_unit.sv
module rotshift_unit
  import rsu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int OP_W    = 6,
  parameter int OP_BASE = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic              c_i,
  input  logic              z_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              z_o
);
  localparam int CNT_W = $clog2(DATA_W);

  rsu_ctl_t          ctl;
  logic [CNT_W-1:0]  amt;
  logic [DATA_W-1:0] sh_in, sh_out, mir_out, comb_res;
  logic              fill_bit, comb_c, comb_z;

  rsu_decode #(.OP_W(OP_W), .OP_BASE(OP_BASE)) u_dec (
    .op (op_i),
    .ctl(ctl)
  );

  assign amt = src_i[CNT_W-1:0];

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      sh_in[i] = ctl.mirror_in ? dst_i[DATA_W-1-i] : dst_i[i];
    end
    case (ctl.fill)
      FILL_CARRY: fill_bit = c_i;
      FILL_SIGN:  fill_bit = dst_i[DATA_W-1];
      default:    fill_bit = 1'b0;
    endcase
  end

  rsu_barrel #(.W(DATA_W), .CW(CNT_W)) u_bar (
    .din     (sh_in),
    .amt     (amt),
    .wrap    (ctl.fill == FILL_WRAP),
    .fill_bit(fill_bit),
    .dout    (sh_out)
  );

  always_comb begin
    for (int i = 0; i < DATA_W; i++) begin
      mir_out[i] = ctl.mirror_out ? sh_out[DATA_W-1-i] : sh_out[i];
    end
    comb_res = ctl.active ? mir_out : dst_i;
  end

  rsu_flags #(.W(DATA_W)) u_flg (
    .active    (ctl.active),
    .c_from_msb(ctl.c_from_msb),
    .dst       (dst_i),
    .res       (comb_res),
    .c_in      (c_i),
    .z_in      (z_i),
    .c_out     (comb_c),
    .z_out     (comb_z)
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        res_o <= '0;
        c_o   <= 1'b0;
        z_o   <= 1'b0;
      end else begin
        res_o <= comb_res;
        c_o   <= comb_c;
        z_o   <= comb_z;
      end
    end

    logic in_group;
    assign in_group = (int'(op_i) >= OP_BASE) && (int'(op_i) < OP_BASE + int'(GROUP_SIZE));

    // R8: zero flag mirrors the registered result
    p_zero_flag_r8: assert property (@(posedge clk) disable iff (rst)
      in_group |=> (z_o == (res_o == '0)));

    // R3: rotate right carry is the old lsb, also for a zero count
    p_ror_carry_r3: assert property (@(posedge clk) disable iff (rst)
      (op_i == OP_W'(OP_BASE)) |=> (c_o == $past(dst_i[0])));

    // R3: rotations keep the number of ones
    p_rot_ones_r3: assert property (@(posedge clk) disable iff (rst)
      ((op_i == OP_W'(OP_BASE)) || (op_i == OP_W'(OP_BASE + 1)))
      |=> ($countones(res_o) == $countones($past(dst_i))));

    // R4: a nonzero logical right shift clears the msb
    p_shr_msb_r4: assert property (@(posedge clk) disable iff (rst)
      ((op_i == OP_W'(OP_BASE + 2)) && (amt != '0)) |=> (res_o[DATA_W-1] == 1'b0));

    // R10: codes outside the group pass operand and flags
    p_idle_pass_r10: assert property (@(posedge clk) disable iff (rst)
      !in_group |=> ((res_o == $past(dst_i)) && (c_o == $past(c_i)) && (z_o == $past(z_i))));
  end else begin : g_comb
    assign res_o = comb_res;
    assign c_o   = comb_c;
    assign z_o   = comb_z;
  end
endmodule

// File: tb/test_rotshift_unit.sv
module test_rotshift_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  op_i;
  logic [31:0] dst_i, src_i;
  logic        c_i, z_i;
  logic [31:0] res_o;
  logic        c_o, z_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  rotshift_unit i_rotshift_unit (
    .clk(clk), .rst(rst), .op_i(op_i), .dst_i(dst_i), .src_i(src_i),
    .c_i(c_i), .z_i(z_i), .res_o(res_o), .c_o(c_o), .z_o(z_o)
  );

  logic [31:0] vals [0:7];
  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
    vals[2] = 32'h0000_0002; vals[3] = 32'h7FFF_FFFF;
    vals[4] = 32'h8000_0000; vals[5] = 32'h8000_0001;
    vals[6] = 32'hFFFF_FFFE; vals[7] = 32'hFFFF_FFFF;
  end

  // reference: bit-by-bit from the requirement formulas
  function automatic logic [32:0] model(input int op, input logic [31:0] d,
                                        input logic [31:0] s, input logic c);
    int n;
    logic [31:0] r;
    logic co;
    n = int'(s % 32);
    for (int i = 0; i < 32; i++) begin
      case (op)
        8:  r[i] = d[(i + n) % 32];
        9:  r[i] = d[(i - n + 32) % 32];
        10: r[i] = (i + n < 32) ? d[i + n] : 1'b0;
        11: r[i] = (i >= n) ? d[i - n] : 1'b0;
        12: r[i] = (i + n < 32) ? d[i + n] : c;
        13: r[i] = (i >= n) ? d[i - n] : c;
        14: r[i] = (i + n < 32) ? d[i + n] : d[31];
        default: r[i] = (i < 32 - n) ? d[31 - n - i] : 1'b0;
      endcase
    end
    co = (op == 9 || op == 11 || op == 13) ? d[31] : d[0];
    return {co, r};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] op, input logic [31:0] d,
                       input logic [31:0] s, input logic c, input logic z);
    @(negedge clk);
    op_i = op; dst_i = d; src_i = s; c_i = c; z_i = z;
    @(negedge clk);
  endtask

  task automatic run_case(input string tag, input int op, input logic [31:0] d,
                          input logic [31:0] s, input logic c, input logic z);
    logic [32:0] e;
    e = model(op, d, s, c);
    apply(6'(op), d, s, c, z);
    check(tag, "result", res_o, e[31:0]);
    check(tag, "carry", {31'b0, c_o}, {31'b0, e[32]});
    check("R8", "zero", {31'b0, z_o}, {31'b0, (e[31:0] == 32'h0)});
  endtask

  task automatic sweep(input string tag, input int op);
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int f = 0; f < 4; f++)
          run_case(tag, op, vals[a], vals[b], f[1], f[0]);
  endtask

  task automatic t_reset;   // R11
    @(negedge clk);
    rst = 1'b1; op_i = 6'd8; dst_i = 32'hFFFF_FFFF; src_i = 0; c_i = 1; z_i = 1;
    @(negedge clk); @(negedge clk);
    check("R11", "reset res", res_o, 32'h0);
    check("R11", "reset flags", {30'b0, c_o, z_o}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_latency;  // R11
    apply(6'd8, 32'h0000_0010, 32'd4, 1'b0, 1'b0);
    @(negedge clk);
    op_i = 6'd8; dst_i = 32'h0000_0100; src_i = 32'd4;
    #1;
    check("R11", "held before edge", res_o, 32'h0000_0001);
    @(negedge clk);
    check("R11", "after edge", res_o, 32'h0000_0010);
  endtask

  task automatic t_order;    // R1
    for (int k = 8; k < 16; k++)
      run_case("R1", k, 32'h0000_00F1, 32'd4, 1'b1, 1'b0);
  endtask

  task automatic t_mask;     // R2
    for (int k = 8; k < 16; k++) begin
      run_case("R2", k, 32'h1234_5679, 32'hFFFF_FFE0, 1'b1, 1'b1);
      run_case("R2", k, 32'h8765_4321, 32'hA5A5_A5E3, 1'b0, 1'b1);
    end
    apply(6'd8, 32'h0000_0001, 32'h7FFF_FFFF, 1'b0, 1'b0);
    check("R2", "count 31", res_o, 32'h0000_0002);
    apply(6'd8, 32'h0000_0001, 32'hFFFF_FFFE, 1'b0, 1'b0);
    check("R2", "count 30", res_o, 32'h0000_0004);
    apply(6'd8, 32'h0000_0001, 32'h8000_0000, 1'b0, 1'b0);
    check("R2", "count 0", res_o, 32'h0000_0001);
  endtask

  task automatic t_carry_fill;  // R5 directed
    apply(6'd12, 32'h0000_0000, 32'd4, 1'b1, 1'b0);
    check("R5", "rcr fill", res_o, 32'hF000_0000);
    apply(6'd13, 32'h0000_0000, 32'd3, 1'b1, 1'b0);
    check("R5", "rcl fill", res_o, 32'h0000_0007);
    apply(6'd12, 32'h0000_0000, 32'd0, 1'b1, 1'b0);
    check("R5", "zero count no fill", res_o, 32'h0);
  endtask

  task automatic t_flag_indep;  // R9
    int ops [6] = '{8, 9, 10, 11, 14, 15};
    foreach (ops[k]) begin
      logic [31:0] r0;
      logic c0, z0;
      apply(6'(ops[k]), 32'h8000_0001, 32'd5, 1'b0, 1'b0);
      r0 = res_o; c0 = c_o; z0 = z_o;
      for (int f = 1; f < 4; f++) begin
        apply(6'(ops[k]), 32'h8000_0001, 32'd5, f[1], f[0]);
        check("R9", "result vs flags", res_o, r0);
        check("R9", "flags vs flags", {30'b0, c_o, z_o}, {30'b0, c0, z0});
      end
    end
  endtask

  task automatic t_idle;     // R10
    int codes [4] = '{0, 7, 16, 63};
    foreach (codes[k])
      for (int f = 0; f < 4; f++) begin
        apply(6'(codes[k]), 32'hDEAD_BEEF, 32'd3, f[1], f[0]);
        check("R10", "pass result", res_o, 32'hDEAD_BEEF);
        check("R10", "pass flags", {30'b0, c_o, z_o}, {30'b0, f[1], f[0]});
      end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; op_i = 0; dst_i = 0; src_i = 0; c_i = 0; z_i = 0;
    t_reset();
    t_latency();
    t_order();
    sweep("R3", 8);
    sweep("R3", 9);
    sweep("R4", 10);
    sweep("R4", 11);
    sweep("R5", 12);
    sweep("R5", 13);
    sweep("R6", 14);
    sweep("R7", 15);
    t_mask();
    t_carry_fill();
    t_flag_indep();
    t_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule